// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a shift register with a parameterised number of stages (eight by default). It can be filled in one step from a parallel input word, or one bit at a time from a serial input. Its output is the last stage, driven in both true and inverted form. It is used to turn a parallel word into a serial bit stream. It can also be cascaded by feeding one unit's last stage into the next unit's serial input.

Shifting is requested through two clock-request inputs that are combined in a NOR fashion. A shift is triggered when one request rises while the other is low. Either input can therefore act as the shift clock, with the other acting as an inhibit. Holding one request high blocks all activity on the other.

The load control is active low and level-sensitive. While it is low, the stages copy the parallel word on every system clock and ignore both clock requests. The two requests and the load control are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the block detects edges on the synchronized values. The serial and parallel data inputs are sampled directly. They must be stable around the cycle in which they are taken.

Top module: `pload_serial_shifter`

## Requirements
- R1: While `rst_n` is low, all stages are cleared on each system clock edge, so `q_last` reads 0 and `q_last_n` reads 1.
- R2: `q_last_n` is always the inverse of `q_last`.
- R3: While the load control is seen low, every stage i takes `par_in[i]`, with stage 0 as the first stage and stage STAGES-1 as the last. The last stage drives `q_last`.
- R4: A load held low copies `par_in` again on every system cycle, so a change on `par_in` reaches `q_last` on the next system clock edge.
- R5: While the load is active, edges on either clock request cause no shift. The load takes priority over a shift detected in the same cycle.
- R6: With the load inactive, a low-to-high change on `clk_a_req` while `clk_b_req` is low causes exactly one shift.
- R7: With the load inactive, a low-to-high change on `clk_b_req` while `clk_a_req` is low causes exactly one shift.
- R8: While either clock request is held high, toggling the other request causes no shift.
- R9: On a shift, stage 0 takes `ser_in` and every other stage takes the previous value of the stage before it. After a load and eight shifts, the loaded word appears on `q_last` from its highest bit down, followed by the serial bits.
- R10: With the load inactive and no qualifying edge, every stage keeps its value.
- R11: A change on `load_n`, `clk_a_req` or `clk_b_req` first affects the stages on the third system clock edge after the change, because of the two-flop synchronizers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Parallel load control, active low, level-sensitive, asynchronous |
| clk_a_req | input | 1 | First shift clock request, asynchronous |
| clk_b_req | input | 1 | Second shift clock request, asynchronous |
| ser_in | input | 1 | Serial data shifted into stage 0 |
| par_in | input | STAGES | Parallel load word; bit i goes to stage i |
| q_last | output | 1 | True value of the last stage |
| q_last_n | output | 1 | Inverted value of the last stage |

## Verification
The hardest case to reach from the ports is the NOR inhibit. The inhibit only works if the held-high request is already high in synchronized form before the other request starts toggling, and the edge detector must see the combined level stay high across every toggle. The stimulus raises one request, waits for the synchronizer depth, and then toggles the other several times. It then swaps the roles of the two requests. A second hard case is a load held across a clock edge. Here the stimulus raises a clock request while the load control is low, so that the detected edge and the active load fall in the same cycle.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  localparam int DEF_STAGES = 8;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } shreg_op_e;

  // NOR-combined clock: a rise of the OR of both requests.
  function automatic logic combined_rise(input logic a_now, input logic b_now,
                                         input logic or_prev);
    return (a_now | b_now) & ~or_prev;
  endfunction

endpackage

// File: rtl/shreg_sync.sv
module shreg_sync #(
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;

endmodule

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
  import shreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_n_s,
  input  logic      clk_a_s,
  input  logic      clk_b_s,
  output shreg_op_e op,
  output logic      shift_evt,
  output logic      load_act
);

  logic or_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) or_prev_q <= 1'b0;
    else        or_prev_q <= clk_a_s | clk_b_s;
  end

  assign shift_evt = combined_rise(clk_a_s, clk_b_s, or_prev_q);
  assign load_act  = ~load_n_s;

  always_comb begin
    if (load_act)       op = OP_LOAD;
    else if (shift_evt) op = OP_SHIFT;
    else                op = OP_HOLD;
  end

endmodule

// File: rtl/shreg_core.sv
module shreg_core
  import shreg_pkg::*;
#(
  parameter int STAGES = DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shreg_op_e         op,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic [STAGES-1:0] stage_q
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = stage_q;
    case (op)
      OP_LOAD:  stage_d = par_in;
      OP_SHIFT: begin
        stage_d[0] = ser_in;
        for (int i = 1; i <= LAST; i++) stage_d[i] = stage_q[i-1];
      end
      default:  stage_d = stage_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

endmodule

// File: rtl/pload_serial_shifter.sv
module pload_serial_shifter
  import shreg_pkg::*;
#(
  parameter int STAGES = DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              clk_a_req,
  input  logic              clk_b_req,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic              q_last,
  output logic              q_last_n
);

  localparam int          NCTL    = 3;
  localparam logic [NCTL-1:0] CTL_IDLE = 3'b100;

  logic [NCTL-1:0]   ctl_s;
  logic              shift_evt;
  logic              load_act;
  shreg_op_e         op;
  logic [STAGES-1:0] stage_q;

  shreg_sync #(.WIDTH(NCTL), .RST_VAL(CTL_IDLE)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({load_n, clk_b_req, clk_a_req}),
    .sync_out (ctl_s)
  );

  shreg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n_s  (ctl_s[2]),
    .clk_a_s   (ctl_s[0]),
    .clk_b_s   (ctl_s[1]),
    .op        (op),
    .shift_evt (shift_evt),
    .load_act  (load_act)
  );

  shreg_core #(.STAGES(STAGES)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .ser_in  (ser_in),
    .par_in  (par_in),
    .stage_q (stage_q)
  );

  assign q_last   = stage_q[STAGES-1];
  assign q_last_n = ~stage_q[STAGES-1];

endmodule

// File: rtl/shreg_checker.sv
module shreg_checker #(
  parameter int STAGES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_n,
  input logic              clk_a_req,
  input logic              clk_b_req,
  input logic              ser_in,
  input logic [STAGES-1:0] par_in,
  input logic [STAGES-1:0] stages,
  input logic              shift_evt,
  input logic              load_act
);

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> stages == '0);

  a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    load_act |=> stages == $past(par_in));

  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load_act && shift_evt) |=> stages == $past(par_in));

  a_r9_shift_move: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && !load_act) |=> stages == {$past(stages[STAGES-2:0]), $past(ser_in)});

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_evt && !load_act) |=> $stable(stages));

  a_r8_nor_edge: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |-> (!$past(clk_a_req, 3) && !$past(clk_b_req, 3)
                   && ($past(clk_a_req, 2) || $past(clk_b_req, 2))));

  a_r11_load_delay: assert property (@(posedge clk) disable iff (!rst_n)
    load_act |-> !$past(load_n, 2));

endmodule

bind pload_serial_shifter shreg_checker #(.STAGES(STAGES)) u_shreg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_n    (load_n),
  .clk_a_req (clk_a_req),
  .clk_b_req (clk_b_req),
  .ser_in    (ser_in),
  .par_in    (par_in),
  .stages    (stage_q),
  .shift_evt (shift_evt),
  .load_act  (load_act)
);

// File: tb/test_pload_serial_shifter.sv
`timescale 1ns/1ps
module test_pload_serial_shifter;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n = 1'b1;
  logic         clk_a_req = 1'b0;
  logic         clk_b_req = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         q_last;
  logic         q_last_n;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";

  // reference model state
  logic [W-1:0] m_reg = '0;
  logic ld_h1 = 1, ld_h2 = 1;
  logic a_h1 = 0, a_h2 = 0, a_h3 = 0;
  logic b_h1 = 0, b_h2 = 0, b_h3 = 0;

  always #5 clk = ~clk;

  pload_serial_shifter #(.STAGES(W)) i_pload_serial_shifter (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .clk_a_req(clk_a_req),
    .clk_b_req(clk_b_req), .ser_in(ser_in), .par_in(par_in),
    .q_last(q_last), .q_last_n(q_last_n)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // One system cycle: model follows the edge, outputs compared mid-cycle.
  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      m_reg = '0;
      ld_h1 = 1; ld_h2 = 1;
      a_h1 = 0; a_h2 = 0; a_h3 = 0;
      b_h1 = 0; b_h2 = 0; b_h3 = 0;
    end else begin
      if (!ld_h2) m_reg = par_in;
      else if ((a_h2 | b_h2) && !(a_h3 | b_h3)) m_reg = {m_reg[W-2:0], ser_in};
      ld_h2 = ld_h1; ld_h1 = load_n;
      a_h3 = a_h2; a_h2 = a_h1; a_h1 = clk_a_req;
      b_h3 = b_h2; b_h2 = b_h1; b_h1 = clk_b_req;
    end
    @(negedge clk);
    check(cur_req, q_last, m_reg[W-1], "q_last vs model");
    check("R2", q_last_n, ~q_last, "q_last_n inverse");
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse(input bit use_b);
    if (use_b) clk_b_req = 1'b1; else clk_a_req = 1'b1;
    steps(3);
    if (use_b) clk_b_req = 1'b0; else clk_a_req = 1'b0;
    steps(3);
  endtask

  initial begin : watchdog
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] word;
    logic         first_ser;
    logic         held;
    @(negedge clk);
    steps(4);
    cur_req = "R1";
    check("R1", q_last, 1'b0, "reset q_last");
    check("R1", q_last_n, 1'b1, "reset q_last_n");
    rst_n = 1'b1;
    steps(3);

    // R3 and R11: one-cycle load, visible on third edge
    cur_req = "R3";
    word = 8'hA5;
    par_in = word;
    load_n = 1'b0;
    step();
    load_n = 1'b1;
    step();
    check("R11", q_last, 1'b0, "no load before sync delay");
    step();
    check("R3", q_last, word[W-1], "loaded last stage");
    steps(2);
    par_in = 8'h00;

    // R6/R7/R9: eight shifts, alternating the clock request
    first_ser = 1'b1;
    for (int i = 1; i <= W; i++) begin
      cur_req = (i % 2 == 1) ? "R6" : "R7";
      ser_in = i[0];
      pulse(i % 2 == 0);
      if (i < W) check("R9", q_last, word[W-1-i], "shifted bit");
      else       check("R9", q_last, first_ser, "first serial bit at end");
    end

    // R8: clk_b held high, clk_a toggled; then swapped
    cur_req = "R8";
    held = q_last;
    clk_b_req = 1'b1;
    steps(4);
    held = q_last;
    for (int k = 0; k < 4; k++) begin
      clk_a_req = 1'b1; ser_in = ~ser_in; steps(3);
      clk_a_req = 1'b0; steps(3);
    end
    check("R8", q_last, held, "clk_a inhibited by clk_b");
    clk_a_req = 1'b1;
    steps(4);
    clk_b_req = 1'b0;
    steps(4);
    for (int k = 0; k < 4; k++) begin
      clk_b_req = 1'b1; steps(3);
      clk_b_req = 1'b0; steps(3);
    end
    check("R8", q_last, held, "clk_b inhibited by clk_a");
    clk_a_req = 1'b0;
    steps(6);

    // R4: held load refreshes every cycle
    cur_req = "R4";
    par_in = 8'h80;
    load_n = 1'b0;
    steps(4);
    check("R4", q_last, 1'b1, "held load first word");
    par_in = 8'h7F;
    step();
    check("R4", q_last, 1'b0, "held load follows par_in");
    par_in = 8'hFF;
    step();
    check("R4", q_last, 1'b1, "held load follows par_in again");

    // R5: clock edges during held load are ignored
    cur_req = "R5";
    par_in = 8'h00;
    ser_in = 1'b1;
    clk_a_req = 1'b1; steps(3);
    clk_a_req = 1'b0; steps(3);
    clk_b_req = 1'b1; steps(3);
    check("R5", q_last, 1'b0, "load wins over clock edges");
    load_n = 1'b1;
    clk_b_req = 1'b0;
    steps(6);

    // R10: idle cycles hold
    cur_req = "R10";
    par_in = 8'hFF;
    held = q_last;
    steps(10);
    check("R10", q_last, held, "hold without edges");

    // R1 again: reset mid-run after loading ones
    cur_req = "R3";
    load_n = 1'b0; steps(4); load_n = 1'b1; steps(3);
    cur_req = "R1";
    rst_n = 1'b0;
    steps(2);
    check("R1", q_last, 1'b0, "reset clears after load");
    rst_n = 1'b1;
    steps(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule